// File: doc/BRIEF.md
# Vector compare predicate generator

This block carries out a conditional-branch compare in vector form. A start request names two source registers and flags each as vectorised or scalar. If at least one source is vectorised, the block walks the elements from index 0 to VL-1, reads one operand pair per cycle from the integer register file, compares them with the requested condition, and collects the results into a bitmask. It then writes that mask once into a chosen destination register. A scalar source keeps feeding the same register to every element. A vectorised source moves forward one register per element.

If neither source is flagged, the instruction is an ordinary branch. The block raises a one-cycle scalar-branch pulse and writes nothing. The surrounding issue logic then handles the branch. The register file is outside the block. The block drives two read addresses, expects the read data in the same cycle, and presents the mask on a write port.

Top module: `vec_cmp_pred`

## Requirements
- R1: When a request is accepted with both vectorised flags low, `scalar_br` is high for exactly the one cycle after the accepting edge, and `pred_we` and `done` stay low for that request.
- R2: For element i, operand A is read from register (src1_reg + i) mod NREG when `src1_vec` is set, and from src1_reg otherwise. Operand B follows the same rule for src2. A scalar operand is therefore compared against every element of the other source.
- R3: Bit i of the written mask is 1 exactly when the compare for element i is true.
- R4: Mask bits at positions VL and above are written as 0. A vector request with VL = 0 writes an all-zero mask.
- R5: `cmp_op` encodings are: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. The encodings 010 and 011 compare false for every element.
- R6: One element is compared per cycle. Counting the accepting edge as edge 0, `pred_we` and `done` are high in the cycle after edge VL, which for VL = 0 is the cycle after the accepting edge.
- R7: Each vector request produces exactly one write. `pred_we` is high for a single cycle, together with `done`, and `pred_waddr` is the `pred_reg` value captured at acceptance.
- R8: `start_ready` is high only while idle. A `start_valid` raised while an operation is in progress is ignored and produces no result.
- R9: A VL input greater than MAXVL is treated as MAXVL.
- R10: Results and timing are the same for both comparator variants selected by `CMP_SUB`.
- R11: During and just after reset, `start_ready` is 1 and `scalar_br`, `pred_we` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Request present |
| start_ready | output | 1 | Block idle; request accepted when both are high |
| src1_reg | input | $clog2(NREG) | First source register index |
| src2_reg | input | $clog2(NREG) | Second source register index |
| src1_vec | input | 1 | First source is vectorised |
| src2_vec | input | 1 | Second source is vectorised |
| cmp_op | input | 3 | Compare condition (branch encoding) |
| vl | input | $clog2(MAXVL+1) | Element count |
| pred_reg | input | $clog2(NREG) | Destination register for the mask |
| rf_addr_a | output | $clog2(NREG) | Read address for operand A |
| rf_addr_b | output | $clog2(NREG) | Read address for operand B |
| rf_data_a | input | XLEN | Read data for operand A, same cycle |
| rf_data_b | input | XLEN | Read data for operand B, same cycle |
| scalar_br | output | 1 | Pulse: ordinary branch should be taken |
| pred_we | output | 1 | Mask write enable |
| pred_waddr | output | $clog2(NREG) | Mask write register index |
| pred_wdata | output | XLEN | Mask value, zero-extended |
| done | output | 1 | Pulse with the mask write |

## Verification
The bench builds the block with XLEN = 8, NREG = 8 and MAXVL = 8, and instantiates it twice, once per comparator variant. With only eight registers, the sweeps make source indices wrap around the register file. With a byte-wide datapath, the signed and unsigned boundary values 0x7F, 0x80, 0x00 and 0xFF are easy to place in the register contents. An 8-element limit lets every compare encoding, every combination of vector flags, and VL values of 0, 1, 3, MAXVL and above MAXVL be swept exhaustively, each against a mask computed arithmetically in the bench. A separate run raises a request while the block is busy, to show that it is dropped.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

   // condition class carried in cmp_op[2:1]; cmp_op[0] inverts the class
   localparam logic [1:0] CLS_EQ  = 2'b00;
   localparam logic [1:0] CLS_NIL = 2'b01;
   localparam logic [1:0] CLS_LT  = 2'b10;
   localparam logic [1:0] CLS_LTU = 2'b11;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_st_e;

endpackage

// File: rtl/vcp_cmp.sv
module vcp_cmp #(
   parameter int XLEN    = 32,
   parameter int CMP_SUB = 0
) (
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  logic [2:0]      cond,
   output logic            hit
);
   import vcp_pkg::*;

   logic is_eq, is_lt, is_ltu, base;

   generate
      if (CMP_SUB != 0) begin : g_sub
         // one shared subtractor derives every relation
         logic [XLEN:0] diff;
         assign diff   = {1'b0, opa} - {1'b0, opb};
         assign is_eq  = (diff[XLEN-1:0] == '0);
         assign is_ltu = diff[XLEN];
         assign is_lt  = (opa[XLEN-1] ^ opb[XLEN-1]) ? opa[XLEN-1] : diff[XLEN];
      end else begin : g_direct
         assign is_eq  = (opa == opb);
         assign is_ltu = (opa < opb);
         assign is_lt  = ($signed(opa) < $signed(opb));
      end
   endgenerate

   always_comb begin
      unique case (cond[2:1])
         CLS_EQ:  base = is_eq;
         CLS_LT:  base = is_lt;
         CLS_LTU: base = is_ltu;
         default: base = 1'b0;
      endcase
      hit = (cond[2:1] == CLS_NIL) ? 1'b0 : (base ^ cond[0]);
   end

endmodule

// File: rtl/vcp_seq.sv
module vcp_seq #(
   parameter int MAXVL = 32,
   localparam int VLW  = $clog2(MAXVL + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_valid,
   input  logic           any_vec,
   input  logic [VLW-1:0] vl_start,
   input  logic [VLW-1:0] vl_run,
   output logic           start_ready,
   output logic           accept,
   output logic           elem_en,
   output logic [VLW-1:0] elem_idx,
   output logic           last,
   output logic           zero_fin,
   output logic           scalar_br,
   output logic           done
);
   import vcp_pkg::*;

   seq_st_e        st_q;
   logic [VLW-1:0] idx_q;
   logic           scal_q, done_q;
   logic           go_run;

   assign start_ready = (st_q == ST_IDLE);
   assign accept      = start_valid & start_ready;
   assign elem_en     = (st_q == ST_RUN);
   assign elem_idx    = idx_q;
   assign last        = elem_en & (idx_q == vl_run - 1'b1);
   assign zero_fin    = accept & any_vec & (vl_start == '0);
   assign go_run      = accept & any_vec & (vl_start != '0);
   assign scalar_br   = scal_q;
   assign done        = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         scal_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         scal_q <= accept & ~any_vec;
         done_q <= last | zero_fin;
         if (go_run) begin
            st_q  <= ST_RUN;
            idx_q <= '0;
         end else if (elem_en) begin
            if (last) st_q  <= ST_IDLE;
            else      idx_q <= idx_q + 1'b1;
         end
      end
   end

   // R6
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elem_en |-> (idx_q < vl_run));

   // R6
   run_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_en && !last) |=> (elem_en && idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/vcp_mask.sv
module vcp_mask #(
   parameter int XLEN  = 32,
   parameter int MAXVL = 32,
   localparam int VLW  = $clog2(MAXVL + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            set_en,
   input  logic [VLW-1:0]  set_idx,
   input  logic            set_val,
   input  logic            fin,
   output logic            wr_en,
   output logic [XLEN-1:0] wr_data
);
   logic [MAXVL-1:0] mask_q, mask_nxt, bit_sel;
   logic             wr_q;
   logic [XLEN-1:0]  wd_q;

   assign bit_sel  = (set_en & set_val) ? (MAXVL'(1) << set_idx) : '0;
   assign mask_nxt = (clr ? '0 : mask_q) | bit_sel;
   assign wr_en    = wr_q;
   assign wr_data  = wd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         wr_q   <= 1'b0;
         wd_q   <= '0;
      end else begin
         mask_q <= mask_nxt;
         wr_q   <= fin;
         if (fin) wd_q <= XLEN'(mask_nxt);
      end
   end

   // R3
   set_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr && set_en));

endmodule

// File: rtl/vec_cmp_pred.sv
module vec_cmp_pred #(
   parameter int XLEN    = 32,
   parameter int NREG    = 32,
   parameter int MAXVL   = 32,
   parameter int CMP_SUB = 0,
   localparam int RW     = $clog2(NREG),
   localparam int VLW    = $clog2(MAXVL + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_valid,
   output logic            start_ready,
   input  logic [RW-1:0]   src1_reg,
   input  logic [RW-1:0]   src2_reg,
   input  logic            src1_vec,
   input  logic            src2_vec,
   input  logic [2:0]      cmp_op,
   input  logic [VLW-1:0]  vl,
   input  logic [RW-1:0]   pred_reg,
   output logic [RW-1:0]   rf_addr_a,
   output logic [RW-1:0]   rf_addr_b,
   input  logic [XLEN-1:0] rf_data_a,
   input  logic [XLEN-1:0] rf_data_b,
   output logic            scalar_br,
   output logic            pred_we,
   output logic [RW-1:0]   pred_waddr,
   output logic [XLEN-1:0] pred_wdata,
   output logic            done
);

   // elaboration-time parameter checks
   if (XLEN < 2) begin : g_bad_xlen
      $error("vec_cmp_pred: XLEN must be at least 2");
   end
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("vec_cmp_pred: NREG must be a power of two, at least 2");
   end
   if (MAXVL < 1 || MAXVL > XLEN) begin : g_bad_maxvl
      $error("vec_cmp_pred: MAXVL must lie in 1..XLEN");
   end
   if (CMP_SUB != 0 && CMP_SUB != 1) begin : g_bad_cmp
      $error("vec_cmp_pred: CMP_SUB must be 0 or 1");
   end

   logic [VLW-1:0] vl_eff;
   logic           any_vec;

   // captured request
   logic [RW-1:0]  j_src1, j_src2, j_dst;
   logic           j_v1, j_v2;
   logic [2:0]     j_op;
   logic [VLW-1:0] j_vl;

   logic           accept, elem_en, last, zero_fin, hit;
   logic [VLW-1:0] elem_idx;
   logic [RW-1:0]  off;

   assign vl_eff  = (vl > VLW'(MAXVL)) ? VLW'(MAXVL) : vl;
   assign any_vec = src1_vec | src2_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         j_src1 <= '0;
         j_src2 <= '0;
         j_dst  <= '0;
         j_v1   <= 1'b0;
         j_v2   <= 1'b0;
         j_op   <= '0;
         j_vl   <= '0;
      end else if (accept) begin
         j_src1 <= src1_reg;
         j_src2 <= src2_reg;
         j_dst  <= pred_reg;
         j_v1   <= src1_vec;
         j_v2   <= src2_vec;
         j_op   <= cmp_op;
         j_vl   <= vl_eff;
      end
   end

   // element offset wraps modulo NREG
   assign off        = RW'(elem_idx);
   assign rf_addr_a  = j_src1 + (j_v1 ? off : '0);
   assign rf_addr_b  = j_src2 + (j_v2 ? off : '0);
   assign pred_waddr = j_dst;

   vcp_seq #(.MAXVL(MAXVL)) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_valid (start_valid),
      .any_vec     (any_vec),
      .vl_start    (vl_eff),
      .vl_run      (j_vl),
      .start_ready (start_ready),
      .accept      (accept),
      .elem_en     (elem_en),
      .elem_idx    (elem_idx),
      .last        (last),
      .zero_fin    (zero_fin),
      .scalar_br   (scalar_br),
      .done        (done)
   );

   vcp_cmp #(.XLEN(XLEN), .CMP_SUB(CMP_SUB)) i_cmp (
      .opa  (rf_data_a),
      .opb  (rf_data_b),
      .cond (j_op),
      .hit  (hit)
   );

   vcp_mask #(.XLEN(XLEN), .MAXVL(MAXVL)) i_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept),
      .set_en  (elem_en),
      .set_idx (elem_idx),
      .set_val (hit),
      .fin     (last | zero_fin),
      .wr_en   (pred_we),
      .wr_data (pred_wdata)
   );

   // R1
   scalar_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scalar_br |-> (!pred_we && !done));

   // R7
   done_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done == pred_we);

   // R7
   wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_we && !start_valid) |=> !pred_we);

   // R4
   mask_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_we |-> ((pred_wdata >> j_vl) == '0));

   // R8
   ready_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_we || scalar_br) |-> start_ready);

endmodule

// File: tb/test_vec_cmp_pred.sv
module test_vec_cmp_pred;

   localparam int XL = 8;
   localparam int NR = 8;
   localparam int MV = 8;
   localparam time HALF = 4ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_valid = 1'b0;
   logic [2:0] s1 = '0, s2 = '0, dst = '0, op = '0;
   logic       v1 = 1'b0, v2 = 1'b0;
   logic [3:0] vl = '0;

   logic       rdy  [2];
   logic       scal [2];
   logic       we   [2];
   logic       dn   [2];
   logic [2:0] ra   [2];
   logic [2:0] rb   [2];
   logic [2:0] wa   [2];
   logic [7:0] rda  [2];
   logic [7:0] rdb  [2];
   logic [7:0] wd   [2];
   logic [7:0] rf   [NR];

   int n_tests = 0;
   int n_fail  = 0;

   always #HALF clk = ~clk;

   for (genvar g = 0; g < 2; g++) begin : g_dut
      vec_cmp_pred #(.XLEN(XL), .NREG(NR), .MAXVL(MV), .CMP_SUB(g)) i_vec_cmp_pred (
         .clk (clk), .rst_n (rst_n),
         .start_valid (start_valid), .start_ready (rdy[g]),
         .src1_reg (s1), .src2_reg (s2), .src1_vec (v1), .src2_vec (v2),
         .cmp_op (op), .vl (vl), .pred_reg (dst),
         .rf_addr_a (ra[g]), .rf_addr_b (rb[g]),
         .rf_data_a (rda[g]), .rf_data_b (rdb[g]),
         .scalar_br (scal[g]), .pred_we (we[g]),
         .pred_waddr (wa[g]), .pred_wdata (wd[g]), .done (dn[g])
      );
      assign rda[g] = rf[ra[g]];
      assign rdb[g] = rf[rb[g]];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit cmp_ref(input int c, input logic [7:0] a, input logic [7:0] b);
      case (c)
         0: return a == b;
         1: return a != b;
         4: return $signed(a) <  $signed(b);
         5: return $signed(a) >= $signed(b);
         6: return a <  b;
         7: return a >= b;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] mask_ref(input int a1, input int a2, input bit f1,
                                           input bit f2, input int c, input int n);
      logic [7:0] m = '0;
      for (int i = 0; i < n; i++) begin
         int ia = f1 ? (a1 + i) % NR : a1;
         int ib = f2 ? (a2 + i) % NR : a2;
         if (cmp_ref(c, rf[ia], rf[ib])) m[i] = 1'b1;
      end
      return m;
   endfunction

   function automatic int vl_pick(input int k);
      case (k)
         0: return 0;
         1: return 1;
         2: return 3;
         3: return 8;
         default: return 12;
      endcase
   endfunction

   task automatic run_op(input int a1, input int a2, input bit f1, input bit f2,
                         input int c, input int n, input int d);
      int vle = (n > MV) ? MV : n;
      int cyc = 0;
      logic [7:0] exp;
      string tag;
      @(negedge clk);
      s1 = 3'(a1); s2 = 3'(a2); v1 = f1; v2 = f2; op = 3'(c); vl = 4'(n); dst = 3'(d);
      start_valid = 1'b1;
      for (int k = 0; k < 2; k++) chk(rdy[k] == 1'b1, "R8", "ready when idle", int'(rdy[k]), 1);
      exp = mask_ref(a1, a2, f1, f2, c, vle);
      @(posedge clk);
      @(negedge clk);
      start_valid = 1'b0;
      if ((f1 | f2) && vle > 0)
         for (int k = 0; k < 2; k++) chk(rdy[k] == 1'b0, "R8", "busy", int'(rdy[k]), 0);
      while (!we[0] && !scal[0] && cyc < 40) begin
         @(negedge clk);
         cyc++;
      end
      if (c == 2 || c == 3)      tag = "R5";
      else if (n > MV)           tag = "R9";
      else if (vle == 0)         tag = "R4";
      else if (f1 ^ f2)          tag = "R2";
      else                       tag = "R3";
      for (int k = 0; k < 2; k++) begin
         if (!(f1 | f2)) begin
            chk(scal[k] == 1'b1, "R1", "scalar_br", int'(scal[k]), 1);
            chk(we[k] == 1'b0 && dn[k] == 1'b0, "R1", "no write", int'(we[k]), 0);
            chk(cyc == 0, "R1", "scalar latency", cyc, 0);
         end else begin
            chk(we[k] == 1'b1 && dn[k] == 1'b1, "R7", "write with done", int'(dn[k]), 1);
            chk(wa[k] == 3'(d), "R7", "write address", int'(wa[k]), d);
            chk(wd[k] == exp, tag, "mask", int'(wd[k]), int'(exp));
            chk((wd[k] >> vle) == 8'h00, "R4", "bits above VL", int'(wd[k]), int'(exp));
            chk(cyc == vle, "R6", "latency", cyc, vle);
         end
         chk(wd[k] == wd[0] && we[k] == we[0] && scal[k] == scal[0], "R10",
             "variant agreement", int'(wd[k]), int'(wd[0]));
      end
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         chk(we[k] == 1'b0 && scal[k] == 1'b0, "R7", "single pulse", int'(we[k]), 0);
         chk(rdy[k] == 1'b1, "R8", "idle after", int'(rdy[k]), 1);
      end
   endtask

   task automatic busy_test();
      int cyc = 0;
      bit saw_scal = 1'b0;
      logic [7:0] exp;
      for (int k = 0; k < NR; k++) rf[k] = 8'(k * 3);
      @(negedge clk);
      s1 = 3'd2; s2 = 3'd0; v1 = 1'b1; v2 = 1'b0; op = 3'd7; vl = 4'd8; dst = 3'd6;
      start_valid = 1'b1;
      exp = mask_ref(2, 0, 1'b1, 1'b0, 7, 8);
      @(posedge clk);
      @(negedge clk);
      // competing scalar request with a different destination while busy
      s1 = 3'd1; s2 = 3'd1; v1 = 1'b0; v2 = 1'b0; dst = 3'd1;
      while (!we[0] && cyc < 40) begin
         if (scal[0] || scal[1]) saw_scal = 1'b1;
         if (cyc == 4) start_valid = 1'b0;
         @(negedge clk);
         cyc++;
      end
      start_valid = 1'b0;
      for (int k = 0; k < 2; k++) begin
         chk(saw_scal == 1'b0, "R8", "request while busy dropped", int'(saw_scal), 0);
         chk(wa[k] == 3'd6, "R8", "first destination kept", int'(wa[k]), 6);
         chk(wd[k] == exp, "R8", "first mask kept", int'(wd[k]), int'(exp));
      end
      repeat (3) begin
         @(negedge clk);
         for (int k = 0; k < 2; k++)
            chk(we[k] == 1'b0 && scal[k] == 1'b0, "R8", "no second result",
                int'(we[k]), 0);
      end
   endtask

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      #(HALF * 2 * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      for (int k = 0; k < NR; k++) rf[k] = '0;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         chk(rdy[k] == 1'b1, "R11", "reset ready", int'(rdy[k]), 1);
         chk(we[k] == 1'b0 && dn[k] == 1'b0 && scal[k] == 1'b0, "R11",
             "reset outputs", int'(we[k]), 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 2; k++)
         chk(rdy[k] == 1'b1 && we[k] == 1'b0, "R11", "after reset", int'(rdy[k]), 1);

      for (int pat = 0; pat < 4; pat++) begin
         for (int k = 0; k < NR; k++) begin
            case (pat)
               0: rf[k] = 8'(k * 37 + 11);
               1: rf[k] = (k % 3 == 0) ? 8'h80 : ((k % 3 == 1) ? 8'h7F : 8'hFF);
               2: rf[k] = (k < 4) ? 8'h05 : 8'hFB;
               default: rf[k] = 8'(k * k * 13 + 200);
            endcase
         end
         for (int c = 0; c < 8; c++)
            for (int vc = 0; vc < 4; vc++)
               for (int vi = 0; vi < 5; vi++)
                  run_op((pat + c + vi) % NR, (pat * 3 + vc + c * 5) % NR,
                         vc[0], vc[1], c, vl_pick(vi), (c + vi) % NR);
      end

      busy_test();
      report();
      $finish;
   end

endmodule